// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block puts the command interpreter of a parallel NOR flash in front of a small on-chip storage array. A host talks to it over a plain bus: an address, write data with a write strobe, and a read strobe that returns read data one cycle later. Each write is either a command byte or the argument or data cycle of a command already in progress. A sequencer tracks which cycle of a multi-cycle command is expected next. Depending on the command, it programs a word, clears a whole sector, accepts a counted burst of words, or only changes what reads return.

Reads are steered by a read mode that the last command selected. The mode picks one of four sources: the array, the status byte, the identifier codes or a built-in capability table. The data width is a parameter of one, two or four bytes. The storage depth and the sector size are parameters too, kept small. No program or erase takes any time: each one finishes on the clock edge that accepts its final write.

Top module: `nor_cmd_ctl`

## Requirements
- R1: After reset every array word reads as all ones, the status byte is 0x80 and reads return array data. The read data output is zero until the first read.
- R2: A write of 0x10 or 0x40 followed by a data write stores the data word at the address of the second write. From then on reads return the status byte, with bit 7 (ready) set, until a write of 0xFF selects the array again.
- R3: A write of 0x20 followed by a write of 0xD0 sets every word of the sector that holds the second address to all ones. The sector is the address aligned down to SECT_LOG2 word bits. Words in other sectors keep their values. Reads then return the status byte, with bit 7 set.
- R4: A write of 0x20 followed by 0xFF, or by any value other than 0xD0, erases nothing and returns reads to the array at once.
- R5: While `read_only` is high, the data cycle of a program, an erase confirm or a burst data cycle leaves the array unchanged and sets status bits 5 and 4 (0x30).
- R6: A write of 0x50 as a command clears the status byte to 0x00 and selects array reads.
- R7: A write of 0x70 selects status reads. The status byte appears in bits 7:0 and all higher bits read zero.
- R8: After 0x90, a read at word address 0 returns `id_mfr`, a read at address 1 returns `id_dev`, and any other address reads zero.
- R9: After 0x98, address bits 7:0 index a capability table. Entries 0x10..0x12 hold "QRY" (0x51, 0x52, 0x59). Entry 0x27 holds log2 of the array size in bytes. Entry 0x2A holds the burst buffer size exponent: 8 for a one-byte width and 11 for wider ones. Entry 0x2D holds the sector count minus one. Entries from 0x40 upward read zero. A write of 0xFF returns reads to the array.
- R10: A write of 0xE8 sets status bit 7 and selects status reads. The next write gives a count N. The next N+1 writes each store their data at their own address, whatever the value, including 0xD0. A following 0xD0 completes the burst and leaves status reads selected.
- R11: A write of 0x60 followed by 0x01 or 0xD0 sets status bit 7, selects status reads and does not alter the array.
- R12: Any other command byte, a second lock cycle other than 0x01, 0xD0 or 0xFF, and a burst closing write other than 0xD0 all return the sequencer to its first cycle with array reads selected.
- R13: Commands are decoded from write data bits 7:0 only. Array data uses the full DATA_BYTES*8 width, with byte lane k in bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address of the access |
| wdata | input | DATA_BYTES*8 | Command, argument or data of a write |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; data appears on the next cycle |
| rdata | output | DATA_BYTES*8 | Registered read data |
| read_only | input | 1 | Array write protection |
| id_mfr | input | 16 | Manufacturer code for identifier reads |
| id_dev | input | 16 | Device code for identifier reads |

## Verification
The hardest state to reach is the burst data phase. It sits two writes deep, under a count the host supplied, and a data word equal to the confirm code must be stored rather than end the burst. The bench gets there with a burst whose last data word is 0x00D0, then checks the closing status read and every stored word. The read-only error path and aborted sequences are reached in the same way: the bench stops a command halfway and reads back both the status and the array.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
    typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT, RD_QUERY} rd_mode_e;
    typedef enum logic [1:0] {CY_IDLE, CY_ARG, CY_DATA, CY_CONF} cyc_e;

    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_CLR      = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_STAT     = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_BUF      = 8'hE8;
    localparam logic [7:0] OP_ARRAY    = 8'hFF;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_LOCK_SET = 8'h01;

    localparam logic [7:0] ST_READY     = 8'h80;
    localparam logic [7:0] ST_ERASE_ERR = 8'h20;
    localparam logic [7:0] ST_PROG_ERR  = 8'h10;
    localparam logic [7:0] ST_BOTH_ERR  = ST_ERASE_ERR | ST_PROG_ERR;
endpackage

// File: rtl/nor_store.sv
module nor_store #(
    parameter int DW        = 16,
    parameter int ADDR_W    = 8,
    parameter int SECT_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int WORDS      = 1 << ADDR_W;
    localparam int SECT_WORDS = 1 << SECT_LOG2;
    localparam int SEC_W      = ADDR_W - SECT_LOG2;

    logic [WORDS*DW-1:0] flat;
    logic [SEC_W-1:0]    sec;

    assign sec   = addr[ADDR_W-1:SECT_LOG2];
    assign rdata = flat[int'(addr)*DW +: DW];

    for (genvar i = 0; i < WORDS; i++) begin : g_cell
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        logic [DW-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (erase && (IDX[ADDR_W-1:SECT_LOG2] == sec)) begin
                word_d = '1;
            end else if (we && (addr == IDX)) begin
                word_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '1;
            else        word_q <= word_d;
        end

        assign flat[i*DW +: DW] = word_q;
    end

    // first and last word of the sector just erased hold all ones
    assert_erase_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (&flat[int'($past(sec)) * SECT_WORDS * DW +: DW]));
    assert_erase_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (&flat[(int'($past(sec)) * SECT_WORDS + SECT_WORDS - 1) * DW +: DW]));
endmodule

// File: rtl/nor_query_rom.sv
module nor_query_rom #(
    parameter int DATA_BYTES = 2,
    parameter int ADDR_W     = 8,
    parameter int SECT_LOG2  = 5
) (
    input  logic [7:0] idx,
    output logic [7:0] val
);
    localparam int TOTAL_LOG2 = ADDR_W + $clog2(DATA_BYTES);
    localparam int NBLK_M1    = (1 << (ADDR_W - SECT_LOG2)) - 1;
    localparam int SECT_BYTES = (1 << SECT_LOG2) * DATA_BYTES;

    logic [7:0] buf_exp;
    if (DATA_BYTES == 1) begin : g_narrow
        assign buf_exp = 8'd8;
    end else begin : g_wide
        assign buf_exp = 8'd11;
    end

    always_comb begin
        val = 8'h00;
        case (idx)
            8'h10: val = 8'h51;
            8'h11: val = 8'h52;
            8'h12: val = 8'h59;
            8'h13: val = 8'h01;
            8'h15: val = 8'h31;
            8'h1B: val = 8'h45;
            8'h1C: val = 8'h55;
            8'h1F: val = 8'h07;
            8'h20: val = 8'h07;
            8'h21: val = 8'h0A;
            8'h23: val = 8'h04;
            8'h24: val = 8'h04;
            8'h25: val = 8'h04;
            8'h27: val = 8'(TOTAL_LOG2);
            8'h28: val = 8'h02;
            8'h2A: val = buf_exp;
            8'h2C: val = 8'h01;
            8'h2D: val = 8'(NBLK_M1);
            8'h2E: val = 8'(NBLK_M1 >> 8);
            8'h2F: val = 8'(SECT_BYTES >> 8);
            8'h30: val = 8'(SECT_BYTES >> 16);
            8'h31: val = 8'h50;
            8'h32: val = 8'h52;
            8'h33: val = 8'h49;
            8'h34: val = 8'h31;
            8'h35: val = 8'h30;
            8'h3F: val = 8'h01;
            default: val = 8'h00;
        endcase
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          read_only,
    output rd_mode_e      mode_o,
    output logic [7:0]    status_o,
    output logic          arr_we_o,
    output logic          arr_erase_o
);
    typedef struct packed {
        rd_mode_e      mode;
        cyc_e          cyc;
        logic [7:0]    op;
        logic [7:0]    status;
        logic [DW-1:0] count;
    } seq_t;

    seq_t       s_d, s_q;
    logic [7:0] op_in;
    logic       we_d, erase_d;

    assign op_in = wdata[7:0];

    always_comb begin
        s_d     = s_q;
        we_d    = 1'b0;
        erase_d = 1'b0;
        if (wr_en) begin
            case (s_q.cyc)
                CY_IDLE: begin
                    s_d.op = op_in;
                    case (op_in)
                        OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK: begin
                            s_d.cyc  = CY_ARG;
                            s_d.mode = RD_STATUS;
                        end
                        OP_BUF: begin
                            s_d.cyc    = CY_ARG;
                            s_d.mode   = RD_STATUS;
                            s_d.status = s_q.status | ST_READY;
                        end
                        OP_CLR: begin
                            s_d.status = 8'h00;
                            s_d.mode   = RD_ARRAY;
                        end
                        OP_STAT:  s_d.mode = RD_STATUS;
                        OP_IDENT: s_d.mode = RD_IDENT;
                        OP_QUERY: s_d.mode = RD_QUERY;
                        default:  s_d.mode = RD_ARRAY;
                    endcase
                end
                CY_ARG: begin
                    s_d.cyc = CY_IDLE;
                    case (s_q.op)
                        OP_PROG_A, OP_PROG_B: begin
                            if (read_only) begin
                                s_d.status = s_q.status | ST_BOTH_ERR;
                            end else begin
                                we_d       = 1'b1;
                                s_d.status = s_q.status | ST_READY;
                            end
                        end
                        OP_ERASE: begin
                            if (op_in == OP_CONFIRM) begin
                                if (read_only) begin
                                    s_d.status = s_q.status | ST_BOTH_ERR;
                                end else begin
                                    erase_d    = 1'b1;
                                    s_d.status = s_q.status | ST_READY;
                                end
                            end else begin
                                s_d.mode = RD_ARRAY;
                            end
                        end
                        OP_LOCK: begin
                            if (op_in == OP_LOCK_SET || op_in == OP_CONFIRM) begin
                                s_d.status = s_q.status | ST_READY;
                            end else begin
                                s_d.mode = RD_ARRAY;
                            end
                        end
                        OP_BUF: begin
                            s_d.count = wdata;
                            s_d.cyc   = CY_DATA;
                        end
                        default: s_d.mode = RD_ARRAY;
                    endcase
                end
                CY_DATA: begin
                    if (read_only) s_d.status = s_q.status | ST_BOTH_ERR;
                    else           we_d = 1'b1;
                    if (s_q.count == '0) s_d.cyc = CY_CONF;
                    else                 s_d.count = s_q.count - 1'b1;
                end
                default: begin
                    s_d.cyc = CY_IDLE;
                    if (op_in == OP_CONFIRM) s_d.status = s_q.status | ST_READY;
                    else                     s_d.mode = RD_ARRAY;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: RD_ARRAY, cyc: CY_IDLE, op: 8'h00, status: ST_READY, count: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o      = s_q.mode;
    assign status_o    = s_q.status;
    assign arr_we_o    = we_d;
    assign arr_erase_o = erase_d;

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_q.cyc == CY_IDLE && wdata[7:0] == OP_CLR)
        |=> (status_o == 8'h00 && mode_o == RD_ARRAY));
    assert_ro_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && read_only && s_q.cyc == CY_ARG && (s_q.op == OP_PROG_A || s_q.op == OP_PROG_B))
        |=> (status_o[5:4] == 2'b11));
    assert_ro_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        read_only |-> !(arr_we_o || arr_erase_o));
    assert_buf_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_q.cyc == CY_IDLE && wdata[7:0] == OP_BUF)
        |=> (status_o[7] && mode_o == RD_STATUS));
    assert_unknown_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_q.cyc == CY_IDLE && wdata[7:0] == 8'h33) |=> (mode_o == RD_ARRAY));
endmodule

// File: rtl/nor_cmd_ctl.sv
module nor_cmd_ctl
    import nor_cmd_pkg::*;
#(
    parameter int DATA_BYTES = 2,
    parameter int ADDR_W     = 8,
    parameter int SECT_LOG2  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_BYTES*8-1:0] wdata,
    input  logic                    wr_en,
    input  logic                    rd_en,
    output logic [DATA_BYTES*8-1:0] rdata,
    input  logic                    read_only,
    input  logic [15:0]             id_mfr,
    input  logic [15:0]             id_dev
);
    localparam int DW = DATA_BYTES * 8;

    rd_mode_e      mode;
    logic [7:0]    status;
    logic          arr_we, arr_erase;
    logic [DW-1:0] arr_rdata;
    logic [7:0]    qidx, qval;
    logic [31:0]   side_word;
    logic [DW-1:0] rdata_d, rdata_q;

    nor_cmd_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .read_only  (read_only),
        .mode_o     (mode),
        .status_o   (status),
        .arr_we_o   (arr_we),
        .arr_erase_o(arr_erase)
    );

    nor_store #(.DW(DW), .ADDR_W(ADDR_W), .SECT_LOG2(SECT_LOG2)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (arr_we),
        .erase(arr_erase),
        .addr (addr),
        .wdata(wdata),
        .rdata(arr_rdata)
    );

    if (ADDR_W >= 8) begin : g_qidx_full
        assign qidx = addr[7:0];
    end else begin : g_qidx_pad
        assign qidx = {{(8 - ADDR_W){1'b0}}, addr};
    end

    nor_query_rom #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W), .SECT_LOG2(SECT_LOG2)) u_rom (
        .idx(qidx),
        .val(qval)
    );

    always_comb begin
        side_word = 32'h0;
        case (mode)
            RD_STATUS: side_word = {24'h0, status};
            RD_QUERY:  side_word = {24'h0, qval};
            RD_IDENT: begin
                if (addr == ADDR_W'(0))      side_word = {16'h0, id_mfr};
                else if (addr == ADDR_W'(1)) side_word = {16'h0, id_dev};
            end
            default: side_word = 32'h0;
        endcase
        rdata_d = rdata_q;
        if (rd_en) rdata_d = (mode == RD_ARRAY) ? arr_rdata : side_word[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    assert_query_sig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == RD_QUERY && qidx == 8'h10) |=> (rdata[7:0] == 8'h51));
    assert_ident_mfr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == RD_IDENT && addr == ADDR_W'(0))
        |=> (rdata[7:0] == $past(id_mfr[7:0])));
    assert_status_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == RD_STATUS) |=> (rdata[7:0] == $past(status)));
endmodule

// File: tb/nor_cmd_ctl_test.sv
module nor_cmd_ctl_test;
    localparam int CLK_P      = 10;
    localparam int DATA_BYTES = 2;
    localparam int ADDR_W     = 8;
    localparam int SECT_LOG2  = 5;
    localparam int DW         = DATA_BYTES * 8;
    localparam int WORDS      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DW-1:0]     rdata;
    logic              read_only = 1'b0;
    logic [15:0]       id_mfr = 16'h0089;
    logic [15:0]       id_dev = 16'h1234;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] shadow [WORDS];

    always #(CLK_P/2) clk = ~clk;

    nor_cmd_ctl #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W), .SECT_LOG2(SECT_LOG2)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .read_only(read_only),
        .id_mfr(id_mfr), .id_dev(id_dev)
    );

    function automatic logic [DW-1:0] exp_query(input logic [7:0] i);
        case (i)
            8'h10: return DW'(8'h51);
            8'h11: return DW'(8'h52);
            8'h12: return DW'(8'h59);
            8'h27: return DW'(ADDR_W + $clog2(DATA_BYTES));
            8'h2A: return DW'((DATA_BYTES == 1) ? 8 : 11);
            8'h2D: return DW'((1 << (ADDR_W - SECT_LOG2)) - 1);
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < WORDS; i++) shadow[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata at reset", rdata, '0);
        rd_chk("R1 erased word", 8'h00, 16'hFFFF);
        rd_chk("R1 erased word", 8'hC7, 16'hFFFF);
        wr(8'h00, 16'h0070);
        rd_chk("R1 R7 reset status", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);

        // R2: random programs with both program codes
        for (int n = 0; n < 24; n++) begin
            logic [ADDR_W-1:0] a;
            logic [DW-1:0]     d;
            a = ADDR_W'($urandom);
            d = DW'($urandom);
            wr(a, (n % 2 == 0) ? 16'h0040 : 16'h0010);
            wr(a, d);
            shadow[a] = d;
            rd_chk("R2 status after program", a, 16'h0080);
            wr(a, 16'h00FF);
            rd_chk("R2 readback", a, shadow[a]);
        end

        // R3: erase sector 0x40..0x5F
        wr(8'h45, 16'h0040); wr(8'h45, 16'h1234); shadow[8'h45] = 16'h1234;
        wr(8'h25, 16'h0040); wr(8'h25, 16'h5678); shadow[8'h25] = 16'h5678;
        wr(8'h60, 16'h0040); wr(8'h60, 16'h9ABC); shadow[8'h60] = 16'h9ABC;
        wr(8'h47, 16'h0020); wr(8'h47, 16'h00D0);
        for (int i = 8'h40; i < 8'h60; i++) shadow[i] = '1;
        rd_chk("R3 status after erase", 8'h47, 16'h0080);
        wr(8'h00, 16'h00FF);
        rd_chk("R3 sector start", 8'h40, 16'hFFFF);
        rd_chk("R3 programmed word", 8'h45, 16'hFFFF);
        rd_chk("R3 sector end", 8'h5F, 16'hFFFF);
        rd_chk("R3 below sector", 8'h25, shadow[8'h25]);
        rd_chk("R3 above sector", 8'h60, shadow[8'h60]);

        // R4: aborted erase
        wr(8'h82, 16'h0040); wr(8'h82, 16'hABCD); shadow[8'h82] = 16'hABCD;
        wr(8'h82, 16'h00FF);
        wr(8'h82, 16'h0020); wr(8'h82, 16'h00FF);
        rd_chk("R4 abort by FF", 8'h82, 16'hABCD);
        wr(8'h82, 16'h0020); wr(8'h82, 16'h0077);
        rd_chk("R4 R12 abort by other", 8'h82, 16'hABCD);

        // R6: clear status
        wr(8'h00, 16'h0050);
        rd_chk("R6 array after clear", 8'h82, 16'hABCD);
        wr(8'h00, 16'h0070);
        rd_chk("R6 status cleared", 8'h00, 16'h0000);

        // R5: read-only
        read_only = 1'b1;
        wr(8'h82, 16'h0040); wr(8'h82, 16'h1111);
        rd_chk("R5 program error bits", 8'h82, 16'h0030);
        wr(8'h82, 16'h00FF);
        rd_chk("R5 array kept on program", 8'h82, 16'hABCD);
        wr(8'h82, 16'h0050);
        wr(8'h82, 16'h0020); wr(8'h82, 16'h00D0);
        rd_chk("R5 erase error bits", 8'h82, 16'h0030);
        wr(8'h82, 16'h00FF);
        rd_chk("R5 array kept on erase", 8'h82, 16'hABCD);
        read_only = 1'b0;
        wr(8'h00, 16'h0050);

        // R8: identifier reads
        wr(8'h00, 16'h0090);
        rd_chk("R8 manufacturer", 8'h00, 16'h0089);
        rd_chk("R8 device", 8'h01, 16'h1234);
        rd_chk("R8 other offset", 8'h02, 16'h0000);
        wr(8'h00, 16'h00FF);

        // R9: capability table
        wr(8'h00, 16'h0098);
        foreach (shadow[k]) begin
            if (k == 8'h10 || k == 8'h11 || k == 8'h12 || k == 8'h27 || k == 8'h2A ||
                k == 8'h2D || k == 8'h40 || k == 8'h82 || k == 8'hFF)
                rd_chk("R9 table entry", ADDR_W'(k), exp_query(8'(k)));
        end
        wr(8'h00, 16'h00FF);
        rd_chk("R9 leave table", 8'h82, 16'hABCD);

        // R10: burst of three words, last one equals confirm code
        wr(8'h00, 16'h0050);
        wr(8'h10, 16'h00E8);
        rd_chk("R10 ready after E8", 8'h10, 16'h0080);
        wr(8'h10, 16'h0002);
        wr(8'h10, 16'hAAAA); shadow[8'h10] = 16'hAAAA;
        wr(8'h11, 16'hBBBB); shadow[8'h11] = 16'hBBBB;
        wr(8'h12, 16'h00D0); shadow[8'h12] = 16'h00D0;
        wr(8'h10, 16'h00D0);
        rd_chk("R10 status after confirm", 8'h10, 16'h0080);
        wr(8'h00, 16'h00FF);
        rd_chk("R10 word 0", 8'h10, shadow[8'h10]);
        rd_chk("R10 word 1", 8'h11, shadow[8'h11]);
        rd_chk("R10 word 2 equals confirm", 8'h12, shadow[8'h12]);
        wr(8'h30, 16'h00E8); wr(8'h30, 16'h0000);
        wr(8'h30, 16'h4321); shadow[8'h30] = 16'h4321;
        wr(8'h30, 16'h0033);
        rd_chk("R10 R12 bad close to array", 8'h30, 16'h4321);

        // R11: lock / unlock
        wr(8'h05, 16'h0050);
        wr(8'h05, 16'h0060); wr(8'h05, 16'h0001);
        rd_chk("R11 lock status", 8'h05, 16'h0080);
        wr(8'h05, 16'h00FF);
        rd_chk("R11 array kept", 8'h05, shadow[8'h05]);
        wr(8'h05, 16'h0050);
        wr(8'h05, 16'h0060); wr(8'h05, 16'h00D0);
        rd_chk("R11 unlock status", 8'h05, 16'h0080);
        wr(8'h05, 16'h0060); wr(8'h05, 16'h0055);
        rd_chk("R11 R12 bad lock arg", 8'h82, 16'hABCD);

        // R12: unknown command from status mode
        wr(8'h00, 16'h0070);
        wr(8'h00, 16'h0033);
        rd_chk("R12 unknown command", 8'h82, 16'hABCD);

        // R13: only low byte decoded; full-width data stored
        wr(8'h07, 16'hAB40); wr(8'h07, 16'hFE01); shadow[8'h07] = 16'hFE01;
        rd_chk("R13 upper status bits zero", 8'h07, 16'h0080);
        wr(8'h07, 16'h12FF);
        rd_chk("R13 full-width word", 8'h07, 16'hFE01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule